// File: doc/BRIEF.md
# Predicated Multicycle 16-bit Processor Core

This block is a small 16-bit processor that steps each instruction through a short series of states. Memory is word-addressed and reached through one port. The port has an address, write data, a write strobe, a read strobe and read data that comes back on the cycle after the read strobe. The core holds four general registers, a flag register, a program counter and a stack pointer. All seven sit in one register file and are selected by a 4-bit index. As a result, any instruction can name the flags, the program counter or the stack pointer as an operand. Writing the program counter is how a jump is made.

Each instruction word carries a condition code, which is tested against the three comparison flags before the instruction takes effect. When the condition fails, the instruction writes no register and makes no memory access. The program counter still moves past the instruction, and past its literal word if it has one. Stack and call instructions take an ordinary register as their pointer, so a program can keep several stacks.

An encoding the core does not define stops it. The core raises a sticky error output and makes no further memory access until the next reset. A one-cycle done pulse marks the end of every instruction that completes.

Top module: `cpu16_core`

## Requirements
- R1: Reset is synchronous and active low. After reset the program counter is 0, the flags and r0–r3 are 0, and the stack pointer is 0x8000. In the first cycle after reset is released the core issues an instruction fetch at address 0.
- R2: An instruction word holds the opcode in bits 15:12, the condition in bits 11:9, the target register index in bits 7:4 and the source register index in bits 3:0. Register indices are r0–r3 = 0–3, flags = 4, program counter = 5 and stack pointer = 6. An instruction that reads index 5 sees the address of that instruction.
- R3: The condition codes are 0 never, 1 not-equal, 2 equal, 3 less-than, 4 greater-than and 7 always. The flag bits are less-than = bit 0, greater-than = bit 1 and equal = bit 2. Not-equal holds when bit 0 or bit 1 is set. When the condition fails, no register or memory changes, and the program counter advances by the instruction's length.
- R4: Opcode 0 loads the target register with the word that follows the instruction, and the program counter advances by 2. If the target is index 5, the instruction jumps to the literal.
- R5: Opcode 1 loads the target register from memory at the address held in the source register. Opcode 2 writes the source register to memory at the address held in the target register.
- R6: Each of these writes its result to the target register. Opcode 3 copies the source register. Opcode 4 adds the source register, modulo 2^16. Opcode 6 ANDs with the source register. Opcode 7 complements the target register.
- R7: Opcode 5 first clears the flag register. It then sets exactly one of equal, less-than or greater-than, from an unsigned comparison of the source register against the target register.
- R8: Opcode 11 shifts the source register right by the target register's value, and opcode 12 shifts it left. The result is written back to the source register. A shift amount of 16 or more gives 0.
- R9: Opcode 8 writes the source register to memory at the address held in the target register, then increments the target register. Opcode 9 decrements the target register, then loads the source register from memory at the decremented address.
- R10: Opcode 10 writes the return address (the call's own address plus 1) to memory at the address held in the target register. It then increments the target register and continues at the address held in the source register.
- R11: Opcodes 13–15 and condition codes 5 or 6 set a sticky error output, whatever the condition is. Once the error is set, the core makes no memory access and completes no instruction until reset.
- R12: A done pulse lasts one cycle and appears on the last cycle of each completed instruction, including one whose condition failed. The cycle after the pulse is a fetch at the new program counter.
- R13: The read strobe and the write strobe are never active together. Read data is taken on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address for the read or write |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after the read strobe |
| insn_done | output | 1 | One-cycle pulse at the end of each completed instruction |
| err | output | 1 | Sticky error after an undefined opcode or condition |

## Verification
The hardest cases to reach from the ports involve register aliasing and conditions. One is an instruction whose condition fails while its literal word would itself decode as an undefined opcode. Another is an instruction that names the program counter or stack pointer as an ordinary operand, as in pop into the pointer, a store addressed by the program counter, or a call that uses the stack pointer. Constrained random programs reach the flag combinations through random compares and random literal writes to the flag register. Directed programs cover the skip-over-literal case, return through a popped address, shifts of 16 or more, and both kinds of illegal encoding. A per-instruction reference model predicts every fetch address and every memory write.

// File: rtl/cpu16_pkg.sv
// cpu16_pkg: shared constants and types for the predicated 16-bit core.
// Assumes a 16-bit instruction word; field positions below are architectural.
package cpu16_pkg;

    // Opcode values (bits 15:12 of the instruction word)
    localparam logic [3:0] OP_LIT   = 4'd0;
    localparam logic [3:0] OP_LOAD  = 4'd1;
    localparam logic [3:0] OP_STORE = 4'd2;
    localparam logic [3:0] OP_COPY  = 4'd3;
    localparam logic [3:0] OP_ADD   = 4'd4;
    localparam logic [3:0] OP_TEST  = 4'd5;
    localparam logic [3:0] OP_AND   = 4'd6;
    localparam logic [3:0] OP_INV   = 4'd7;
    localparam logic [3:0] OP_PUSH  = 4'd8;
    localparam logic [3:0] OP_POP   = 4'd9;
    localparam logic [3:0] OP_CALL  = 4'd10;
    localparam logic [3:0] OP_SHR   = 4'd11;
    localparam logic [3:0] OP_SHL   = 4'd12;
    localparam logic [3:0] OP_LAST  = OP_SHL;

    // Condition codes (bits 11:9)
    localparam logic [2:0] CC_NEVER  = 3'd0;
    localparam logic [2:0] CC_NE     = 3'd1;
    localparam logic [2:0] CC_EQ     = 3'd2;
    localparam logic [2:0] CC_LT     = 3'd3;
    localparam logic [2:0] CC_GT     = 3'd4;
    localparam logic [2:0] CC_ALWAYS = 3'd7;

    // Flag bit positions inside the flag register
    localparam int FLB_LT = 0;
    localparam int FLB_GT = 1;
    localparam int FLB_EQ = 2;
    localparam int FLAG_W = 3;

    // Register-file indices with architectural meaning
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] IDX_FLAGS = 4'd4;
    localparam logic [IDX_W-1:0] IDX_PC    = 4'd5;
    localparam logic [IDX_W-1:0] IDX_SP    = 4'd6;

    // Decoded view of an instruction word
    typedef struct packed {
        logic [3:0]       op;
        logic [2:0]       cc;
        logic             spare;
        logic [IDX_W-1:0] tgt;
        logic [IDX_W-1:0] src;
    } insn_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LITW,
        ST_LOADW,
        ST_POPW,
        ST_HALT
    } step_e;

endpackage

// File: rtl/cpu16_cond.sv
// cpu16_cond: evaluates an instruction's condition code against the flags.
// Assumes flags in the layout of cpu16_pkg; codes 5 and 6 are reported as undefined.
module cpu16_cond
    import cpu16_pkg::*;
(
    input  logic [2:0]        cc,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass,
    output logic              undef
);

    // Map condition code to a pass decision and an undefined-code indication
    always_comb begin
        pass  = 1'b0;
        undef = 1'b0;
        case (cc)
            CC_NEVER:  pass = 1'b0;
            CC_NE:     pass = flags[FLB_LT] | flags[FLB_GT];
            CC_EQ:     pass = flags[FLB_EQ];
            CC_LT:     pass = flags[FLB_LT];
            CC_GT:     pass = flags[FLB_GT];
            CC_ALWAYS: pass = 1'b1;
            default:   undef = 1'b1;
        endcase
    end

endmodule

// File: rtl/cpu16_alu.sv
// cpu16_alu: single-cycle datapath for all register-to-register results.
// Assumes operands are the target and source register values of the current
// instruction; also forms pointer increment and decrement for stack opcodes.
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]        op,
    input  logic [W-1:0]      tgt_v,
    input  logic [W-1:0]      src_v,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] cmp
);

    localparam int SHW = $clog2(W);

    logic              shift_out;   // amount reaches the word width
    logic [SHW-1:0]    sh_amt;

    assign shift_out = (tgt_v > W'(W - 1));
    assign sh_amt    = tgt_v[SHW-1:0];

    // Result selection per opcode
    always_comb begin
        case (op)
            OP_COPY: res = src_v;
            OP_ADD:  res = tgt_v + src_v;
            OP_AND:  res = tgt_v & src_v;
            OP_INV:  res = ~tgt_v;
            OP_SHR:  res = shift_out ? '0 : (src_v >> sh_amt);
            OP_SHL:  res = shift_out ? '0 : (src_v << sh_amt);
            OP_PUSH: res = tgt_v + W'(1);
            OP_CALL: res = tgt_v + W'(1);
            OP_POP:  res = tgt_v - W'(1);
            default: res = src_v;
        endcase
    end

    // Unsigned comparison of source against target for the test opcode
    always_comb begin
        cmp         = '0;
        cmp[FLB_LT] = (src_v <  tgt_v);
        cmp[FLB_GT] = (src_v >  tgt_v);
        cmp[FLB_EQ] = (src_v == tgt_v);
    end

endmodule

// File: rtl/cpu16_regfile.sv
// cpu16_regfile: architectural registers (general, flags, PC, SP) in one array.
// One general write port plus a dedicated PC update port; a general write to
// the PC index wins over the PC port. Indices at or above NREG read as zero and
// are not written.
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int             W       = 16,
    parameter int             NREG    = 7,
    parameter logic [W-1:0]   SP_INIT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [W-1:0]      ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [W-1:0]      rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [W-1:0]      wr_data,
    input  logic              pc_we,
    input  logic [W-1:0]      pc_d,
    output logic [W-1:0]      pc_q,
    output logic [FLAG_W-1:0] flags_q
);

    localparam int SELW = $clog2(NREG);

    logic [W-1:0] q [NREG];

    // Reset value for each register slot
    function automatic logic [W-1:0] init_val(input int i);
        return (i == int'(IDX_SP)) ? SP_INIT : '0;
    endfunction

    // Register update: reset, general write, then PC port
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                q[i] <= init_val(i);
            else if (wr_en && wr_idx == IDX_W'(i))
                q[i] <= wr_data;
            else if (i == int'(IDX_PC) && pc_we)
                q[i] <= pc_d;
        end
    end

    assign ra_data = (int'(ra_idx) < NREG) ? q[ra_idx[SELW-1:0]] : '0;
    assign rb_data = (int'(rb_idx) < NREG) ? q[rb_idx[SELW-1:0]] : '0;
    assign pc_q    = q[int'(IDX_PC)];
    assign flags_q = q[int'(IDX_FLAGS)][FLAG_W-1:0];

endmodule

// File: rtl/cpu16_core.sv
// cpu16_core: predicated multicycle 16-bit processor, top level.
// Sequences fetch, decode and execute over one memory port whose read data
// arrives the cycle after the read strobe. Undefined opcodes or condition
// codes halt the core with a sticky error until reset.
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int           W       = 16,
    parameter int           NREG    = 7,
    parameter logic [W-1:0] SP_INIT = 16'h8000
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    output logic         mem_re,
    input  logic [W-1:0] mem_rdata,
    output logic         insn_done,
    output logic         err
);

    step_e             st, st_nx;
    insn_t             ir;
    logic [W-1:0]      vt, vs, pc_q, alu_res;
    logic [FLAG_W-1:0] flags_q, cmp;
    logic              cc_pass, cc_undef, op_undef, err_set;
    logic              rf_we, pc_we;
    logic [IDX_W-1:0]  rf_widx;
    logic [W-1:0]      rf_wd, pc_d;
    logic              unused_spare;

    assign unused_spare = ir.spare;
    assign op_undef     = (ir.op > OP_LAST);

    cpu16_regfile #(.W(W), .NREG(NREG), .SP_INIT(SP_INIT)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ir.tgt),
        .ra_data (vt),
        .rb_idx  (ir.src),
        .rb_data (vs),
        .wr_en   (rf_we),
        .wr_idx  (rf_widx),
        .wr_data (rf_wd),
        .pc_we   (pc_we),
        .pc_d    (pc_d),
        .pc_q    (pc_q),
        .flags_q (flags_q)
    );

    cpu16_cond cond_i (
        .cc    (ir.cc),
        .flags (flags_q),
        .pass  (cc_pass),
        .undef (cc_undef)
    );

    cpu16_alu #(.W(W)) alu_i (
        .op    (ir.op),
        .tgt_v (vt),
        .src_v (vs),
        .res   (alu_res),
        .cmp   (cmp)
    );

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FETCH;
        else        st <= st_nx;
    end

    // Instruction register, loaded from the fetch read data
    always_ff @(posedge clk) begin
        if (!rst_n)              ir <= '0;
        else if (st == ST_DECODE) ir <= insn_t'(mem_rdata);
    end

    // Sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_set) err <= 1'b1;
    end

    // Per-state control: memory strobes, register writes, PC update, next state
    always_comb begin
        st_nx     = st;
        mem_addr  = pc_q;
        mem_wdata = vs;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        rf_we     = 1'b0;
        rf_widx   = ir.tgt;
        rf_wd     = alu_res;
        pc_we     = 1'b0;
        pc_d      = pc_q + W'(1);
        insn_done = 1'b0;
        err_set   = 1'b0;
        case (st)
            ST_FETCH: begin
                mem_re = 1'b1;
                st_nx  = ST_DECODE;
            end
            ST_DECODE: begin
                st_nx = ST_EXEC;
            end
            ST_EXEC: begin
                if (op_undef || cc_undef) begin
                    err_set = 1'b1;
                    st_nx   = ST_HALT;
                end else begin
                    pc_we     = 1'b1;
                    insn_done = 1'b1;
                    st_nx     = ST_FETCH;
                    case (ir.op)
                        OP_LIT: begin
                            if (cc_pass) begin
                                mem_re    = 1'b1;
                                mem_addr  = pc_q + W'(1);
                                pc_we     = 1'b0;
                                insn_done = 1'b0;
                                st_nx     = ST_LITW;
                            end else begin
                                pc_d = pc_q + W'(2);
                            end
                        end
                        OP_LOAD: begin
                            if (cc_pass) begin
                                mem_re    = 1'b1;
                                mem_addr  = vs;
                                pc_we     = 1'b0;
                                insn_done = 1'b0;
                                st_nx     = ST_LOADW;
                            end
                        end
                        OP_STORE: begin
                            if (cc_pass) begin
                                mem_we   = 1'b1;
                                mem_addr = vt;
                            end
                        end
                        OP_TEST: begin
                            rf_we   = cc_pass;
                            rf_widx = IDX_FLAGS;
                            rf_wd   = {{(W-FLAG_W){1'b0}}, cmp};
                        end
                        OP_SHR, OP_SHL: begin
                            rf_we   = cc_pass;
                            rf_widx = ir.src;
                        end
                        OP_PUSH: begin
                            if (cc_pass) begin
                                mem_we   = 1'b1;
                                mem_addr = vt;
                                rf_we    = 1'b1;
                            end
                        end
                        OP_POP: begin
                            if (cc_pass) begin
                                rf_we     = 1'b1;
                                mem_re    = 1'b1;
                                mem_addr  = alu_res;
                                insn_done = 1'b0;
                                st_nx     = ST_POPW;
                            end
                        end
                        OP_CALL: begin
                            if (cc_pass) begin
                                mem_we    = 1'b1;
                                mem_addr  = vt;
                                mem_wdata = pc_q + W'(1);
                                rf_we     = 1'b1;
                                pc_d      = vs;
                            end
                        end
                        default: begin
                            rf_we = cc_pass;
                        end
                    endcase
                end
            end
            ST_LITW: begin
                rf_we     = 1'b1;
                rf_wd     = mem_rdata;
                pc_we     = 1'b1;
                pc_d      = pc_q + W'(2);
                insn_done = 1'b1;
                st_nx     = ST_FETCH;
            end
            ST_LOADW: begin
                rf_we     = 1'b1;
                rf_wd     = mem_rdata;
                pc_we     = 1'b1;
                insn_done = 1'b1;
                st_nx     = ST_FETCH;
            end
            ST_POPW: begin
                rf_we     = 1'b1;
                rf_widx   = ir.src;
                rf_wd     = mem_rdata;
                insn_done = 1'b1;
                st_nx     = ST_FETCH;
            end
            default: begin
                st_nx = ST_HALT;
            end
        endcase
    end

endmodule

// File: rtl/cpu16_core_chk.sv
// cpu16_core_chk: port-level temporal checks for cpu16_core, attached by bind.
module cpu16_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mem_addr,
    input logic         mem_we,
    input logic         mem_re,
    input logic         insn_done,
    input logic         err
);

    // R1
    reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mem_re && mem_addr == '0 && !err));

    // R13
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_re && !mem_we && !insn_done));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> !insn_done);

    // R12
    fetch_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> (mem_re && !mem_we));

endmodule

bind cpu16_core cpu16_core_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .insn_done (insn_done),
    .err       (err)
);

// File: tb/cpu16_core_tb_top.sv
// Lockstep bench: a per-instruction reference model predicts fetch addresses
// and memory writes; random and directed programs drive the core.
module cpu16_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, insn_done, err;

    always #5 clk = ~clk;

    cpu16_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .insn_done(insn_done), .err(err)
    );

    logic [15:0] rom  [2048];
    logic [15:0] dram [2048];
    logic [15:0] mram [2048];
    logic [15:0] m_regs [7];
    int n_chk = 0, n_bad = 0, pc_w = 0, end_pc = 0;

    // Memory: low half is program storage (writes dropped), high half is RAM
    function automatic logic [15:0] brd(input logic [15:0] a);
        return a[15] ? dram[a[10:0]] : rom[a[10:0]];
    endfunction
    function automatic logic [15:0] mrd(input logic [15:0] a);
        return a[15] ? mram[a[10:0]] : rom[a[10:0]];
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= brd(mem_addr);
        if (mem_we && mem_addr[15]) dram[mem_addr[10:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int cc, input int t, input int s);
        return {4'(op), 3'(cc), 1'b0, 4'(t), 4'(s)};
    endfunction

    task automatic emit(input logic [15:0] w);
        rom[pc_w[10:0]] = w;
        pc_w++;
    endtask

    function automatic logic [15:0] mreg(input logic [3:0] i);
        return (i < 4'd7) ? m_regs[i[2:0]] : 16'h0;
    endfunction

    task automatic mset(input logic [3:0] i, input logic [15:0] v);
        if (i < 4'd7) m_regs[i[2:0]] = v;
    endtask

    function automatic bit m_cond(input logic [2:0] cc, input logic [15:0] f);
        case (cc)
            3'd1: return f[0] | f[1];
            3'd2: return f[2];
            3'd3: return f[0];
            3'd4: return f[1];
            3'd7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_illegal(input logic [15:0] w);
        return (w[15:12] > 4'd12) || (w[11:9] == 3'd5) || (w[11:9] == 3'd6);
    endfunction

    // Reference step of one instruction; returns the expected memory write
    task automatic model_step(output bit we, output logic [15:0] wa, output logic [15:0] wd,
                              output string tag);
        logic [15:0] w, pc, vt, vs, r;
        logic [3:0]  t, s;
        bit ok;
        pc = m_regs[5];
        w  = mrd(pc);
        t  = w[7:4]; s = w[3:0];
        vt = mreg(t); vs = mreg(s);
        ok = m_cond(w[11:9], m_regs[4]);
        we = 0; wa = 0; wd = 0;
        m_regs[5] = pc + 16'd1;
        case (w[15:12])
            4'd0: tag = "R4";
            4'd1, 4'd2: tag = (t == 4'd5) ? "R2" : "R5";
            4'd5: tag = "R7";
            4'd8, 4'd9: tag = "R9";
            4'd10: tag = "R10";
            4'd11, 4'd12: tag = "R8";
            default: tag = "R6";
        endcase
        if (!ok) tag = "R3";
        if (w[15:12] == 4'd0) m_regs[5] = pc + 16'd2;
        if (ok) begin
            case (w[15:12])
                4'd0: mset(t, mrd(pc + 16'd1));
                4'd1: mset(t, mrd(vs));
                4'd2: begin we = 1; wa = vt; wd = vs; end
                4'd3: mset(t, vs);
                4'd4: mset(t, vt + vs);
                4'd5: mset(4'd4, {13'd0, (vs == vt), (vs > vt), (vs < vt)});
                4'd6: mset(t, vt & vs);
                4'd7: mset(t, ~vt);
                4'd8: begin we = 1; wa = vt; wd = vs; mset(t, vt + 16'd1); end
                4'd9: begin mset(t, vt - 16'd1); mset(s, mrd(vt - 16'd1)); end
                4'd10: begin we = 1; wa = vt; wd = pc + 16'd1; mset(t, vt + 16'd1);
                             m_regs[5] = vs; end
                4'd11: begin r = (vt > 16'd15) ? 16'h0 : (vs >> vt[3:0]); mset(s, r); end
                default: begin r = (vt > 16'd15) ? 16'h0 : (vs << vt[3:0]); mset(s, r); end
            endcase
        end
        if (we && wa[15]) mram[wa[10:0]] = wd;
    endtask

    // Reset the core and the model, then run in lockstep until the end loop
    task automatic run_prog(input bit sp_chk);
        bit          expect_fetch = 1, first = 1, ewe;
        int          nwe = 0, cyc = 0;
        logic [15:0] wa_s = 0, wd_s = 0, ewa, ewd;
        string       tag;
        for (int i = 0; i < 2048; i++) begin dram[i] = 16'h0; mram[i] = 16'h0; end
        for (int i = 0; i < 7; i++) m_regs[i] = 16'h0;
        m_regs[6] = 16'h8000;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        forever begin
            if (mem_re || mem_we)
                check(!(mem_re && mem_we), "R13", "both strobes", {mem_re, mem_we}, 2'b00);
            if (mem_we) begin nwe++; wa_s = mem_addr; wd_s = mem_wdata;
                if (sp_chk) begin
                    check(mem_wdata == 16'h8000, "R1", "stack pointer after reset", mem_wdata, 16'h8000);
                    sp_chk = 0;
                end
            end
            if (expect_fetch && mem_re) begin
                check(mem_addr == m_regs[5] && !err, first ? "R1" : "R12", "fetch address",
                      mem_addr, m_regs[5]);
                expect_fetch = 0; first = 0;
                if (m_illegal(mrd(m_regs[5]))) begin
                    repeat (3) @(negedge clk);
                    check(err == 1'b1, "R11", "error raised", err, 1);
                    for (int k = 0; k < 4; k++) begin
                        @(negedge clk);
                        check(err && !mem_re && !mem_we && !insn_done, "R11", "halted quiet",
                              {err, mem_re, mem_we, insn_done}, 4'b1000);
                    end
                    return;
                end
            end
            if (insn_done) begin
                model_step(ewe, ewa, ewd, tag);
                if (ewe || nwe != 0)
                    check(nwe == int'(ewe) && wa_s == ewa && wd_s == ewd, tag, "memory write",
                          {wa_s, wd_s}, {ewa, ewd});
                nwe = 0; expect_fetch = 1;
                if (int'(m_regs[5]) == end_pc) return;
            end
            cyc++;
            if (cyc > 20000) begin
                check(0, "R12", "instruction stream stalled", cyc, 0);
                return;
            end
            @(negedge clk);
        end
    endtask

    function automatic int rreg();
        int pick [6] = '{0, 1, 2, 3, 4, 6};
        return pick[$urandom_range(0, 5)];
    endfunction

    task automatic build_random(input int n);
        int ccs [6] = '{0, 1, 2, 3, 4, 7};
        pc_w = 0;
        for (int i = 0; i < n; i++) begin
            int op = $urandom_range(0, 12);
            int cc = ($urandom_range(0, 2) == 0) ? 7 : ccs[$urandom_range(0, 5)];
            if (op == 10) op = 5;
            emit(enc(op, cc, rreg(), rreg()));
            if (op == 0)
                emit(($urandom_range(0, 1) == 1) ? {1'b1, 15'($urandom_range(0, 40))}
                                                 : 16'($urandom_range(0, 20)));
        end
        for (int x = 0; x < 7; x++) if (x != 5) emit(enc(2, 7, 5, x));
        end_pc = pc_w;
        emit(enc(0, 7, 5, 0)); emit(16'(end_pc));
    endtask

    task automatic build_directed();
        int skip_at, call_at, sub_at;
        pc_w = 0;
        emit(enc(2, 7, 5, 6));                         // reset SP seen (R1)
        emit(enc(2, 7, 5, 4)); emit(enc(2, 7, 5, 0));
        emit(enc(0, 7, 0, 0)); emit(16'hFFFF);
        emit(enc(0, 7, 1, 0)); emit(16'h0001);
        emit(enc(4, 7, 0, 1));                         // wraps to 0 (R6)
        emit(enc(5, 7, 0, 1));                         // source greater (R7)
        emit(enc(0, 2, 2, 0)); emit(16'hF000);         // false: literal skipped (R3)
        emit(enc(0, 1, 5, 0)); skip_at = pc_w; emit(16'h0);
        emit(16'hF000);                                // jumped over (R4)
        rom[skip_at[10:0]] = 16'(pc_w);
        emit(enc(2, 7, 5, 2));
        emit(enc(0, 7, 2, 0)); emit(16'd20);
        emit(enc(0, 7, 3, 0)); emit(16'hABCD);
        emit(enc(11, 7, 2, 3)); emit(enc(2, 7, 5, 3)); // shift by 20 gives 0 (R8)
        emit(enc(0, 7, 2, 0)); emit(16'd4);
        emit(enc(0, 7, 3, 0)); emit(16'h0F0F);
        emit(enc(12, 7, 2, 3)); emit(enc(2, 7, 5, 3));
        emit(enc(11, 7, 2, 3)); emit(enc(2, 7, 5, 3));
        emit(enc(8, 7, 6, 3)); emit(enc(9, 7, 6, 0)); emit(enc(2, 7, 5, 0)); // R9
        emit(enc(5, 0, 0, 0)); emit(enc(2, 7, 5, 4));
        emit(enc(0, 7, 1, 0)); call_at = pc_w; emit(16'h0);
        emit(enc(10, 7, 6, 1));                        // R10
        emit(enc(2, 7, 5, 6)); emit(enc(2, 7, 5, 0));
        end_pc = pc_w;
        emit(enc(0, 7, 5, 0)); emit(16'(end_pc));
        sub_at = pc_w;
        rom[call_at[10:0]] = 16'(sub_at);
        emit(enc(9, 7, 6, 2)); emit(enc(2, 7, 5, 2));
        emit(enc(0, 7, 0, 0)); emit(16'h7777);
        emit(enc(3, 7, 5, 2));                         // return via copy to PC (R2)
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R12", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        for (int i = 0; i < 2048; i++) rom[i] = 16'h0;
        build_directed();
        run_prog(1);
        for (int r = 0; r < 4; r++) begin
            build_random(120);
            run_prog(0);
        end
        pc_w = 0; emit(enc(0, 7, 0, 0)); emit(16'h1); emit(enc(0, 5, 0, 0));
        run_prog(0);                                   // undefined condition (R11)
        pc_w = 0; emit(enc(13, 0, 1, 2));
        run_prog(0);                                   // undefined opcode, never-cond (R11)
        build_directed();
        run_prog(1);                                   // reset clears error (R1)
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule